// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives data words from a single serial data line while driving the serial clock itself. A programmable divider sets the rate of the serial clock. The clock idles low. Each received bit is sampled on the clock's falling edge, and bits arrive least significant first. A word holds either 8 or 9 bits. When a word is complete it moves into a holding register and raises a receive-complete flag. That flag can also drive an interrupt.

Software controls the block through a small register port of four byte-wide locations:

- **Control register (address 0).** Holds the enable bits.
- **Divider register (address 1).** Sets the serial clock rate.
- **Status register (address 2).** Read-only flags.
- **Data register (address 3).** Reading it with the read strobe clears the receive-complete flag.

Reception has two modes:

- **One-shot mode.** Receives a single word, then clears its own enable.
- **Continuous mode.** Receives words back to back until its enable is cleared. When both enables are set, continuous mode wins.

If a word finishes while the previous word is still unread, the new word is discarded and an overrun flag is set. The overrun flag clears when software writes the continuous enable from 1 to 0.

The state machine has four states:

- **ST_IDLE.** The clock is low and nothing is shifting.
- **ST_LOW.** The low half of a bit cell.
- **ST_HIGH.** The high half of a bit cell.
- **ST_DONE.** One cycle that hands the word to the registers.

It has these transitions:

- **IDLE→LOW.** Taken when the port is enabled and either receive enable is set.
- **LOW→HIGH.** Taken on a divider tick.
- **HIGH→LOW.** Taken on a divider tick, after the bit is sampled, when more bits remain.
- **HIGH→DONE.** Taken on the tick that samples the last bit.
- **DONE→LOW.** Taken when continuous mode is still enabled.
- **DONE→IDLE.** Taken in every other case.
- **LOW/HIGH→IDLE (abort).** Taken as soon as the receive condition goes away. A partly received word is dropped.

Top module: `sync_master_rx`

## Requirements
- R1: After reset, all four register locations read 0, `sclk_o` is low and `irq_o` is low.
- R2: Reception runs only while control bit 0 (port enable) is 1 and control bit 1 (one-shot enable) or control bit 2 (continuous enable) is 1. With port enable 0, `sclk_o` stays low and no word is received.
- R3: Each half period of `sclk_o` lasts DIV+1 clock cycles, where DIV is the divider register value. A word starts with a low half, and `sclk_o` is low in idle. A bit is sampled on each falling edge of `sclk_o`, and the first bit sampled becomes bit 0 of the word.
- R4: In one-shot mode exactly one word is received. Control bit 1 reads 0 once the word has reached the holding register, and `sclk_o` returns to low.
- R5: In continuous mode, words follow back to back. Each receive-complete flag comes 2·N·(DIV+1)+1 cycles after the previous one, where N is the number of bits per word. Control bit 2 stays set, and clearing it stops reception.
- R6: With both enables set, reception continues after the first word, as in continuous mode, and control bit 1 is cleared after that first word.
- R7: Control bit 3 selects 9-bit words. The ninth bit (word bit 8) reads in status bit 2, and bits 7:0 read at the data register (address 3).
- R8: Status bit 0 (receive complete) sets when a word finishes. A read of address 3 with `rd_en` high clears it at the next clock edge.
- R9: `irq_o` is high only when status bit 0 and control bit 4 (interrupt enable) are both 1.
- R10: If a word finishes while status bit 0 is still 1, status bit 1 (overrun) sets, and the data register and status bit 2 keep their old values.
- R11: A control write that changes control bit 2 from 1 to 0 clears status bit 1.
- R12: In one-shot mode status bit 0 sets exactly 2·N·(DIV+1)+2 cycles after the clock edge that writes the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears the receive-complete flag when `addr` is 3 |
| addr | input | 2 | Register address: 0 control, 1 divider, 2 status, 3 data |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| sclk_o | output | 1 | Generated serial clock, idles low |
| sdata_i | input | 1 | Serial data input |
| irq_o | output | 1 | Receive-complete interrupt |

## Verification
A one-shot word sets the receive-complete flag 2·N·(DIV+1)+2 cycles after the control write edge. The bench checks the flag is still clear one cycle before that and set exactly at it. The first rising edge of `sclk_o` comes DIV+2 cycles after the write edge and lasts DIV+1 cycles, and it is checked at those cycles. In continuous mode the spacing between successive flags is measured against 2·N·(DIV+1)+1. All register effects of a read or write are sampled at the falling clock edge after the rising edge that applies them, and outputs are always read 1 ns after a falling edge.

// File: rtl/smr_pkg.sv
package smr_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_DONE = 2'd3
    } smr_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;
    localparam logic [1:0] A_DATA = 2'd3;

    localparam int C_PORT   = 0;
    localparam int C_SINGLE = 1;
    localparam int C_CONT   = 2;
    localparam int C_NINE   = 3;
    localparam int C_IRQEN  = 4;

endpackage

// File: rtl/smr_baud.sv
module smr_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= div;
        end else if (cnt_q == '0) begin
            cnt_q <= div;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/smr_fsm.sv
module smr_fsm
    import smr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        keep_on,
    input  logic        nine,
    input  logic        tick,
    input  logic        sdata,
    output logic        sclk,
    output logic        shifting,
    output logic        fsm_idle,
    output logic        word_valid,
    output logic [DW:0] word
);

    localparam int CW = $clog2(DW + 1) + 1;

    smr_state_e      state_q, state_d;
    logic [CW-1:0]   bitcnt_q;
    logic [DW:0]     shreg_q;
    logic            sclk_q;
    logic            last_bit;

    assign last_bit = (bitcnt_q == (nine ? CW'(DW) : CW'(DW - 1)));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!go)       state_d = ST_IDLE;
                else if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!go)           state_d = ST_IDLE;
                else if (tick)     state_d = last_bit ? ST_DONE : ST_LOW;
            end
            ST_DONE: begin
                state_d = (go && keep_on) ? ST_LOW : ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            sclk_q   <= 1'b0;
        end else begin
            sclk_q <= (state_d == ST_HIGH);
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    bitcnt_q <= '0;
                    if (state_d == ST_LOW) shreg_q <= '0;
                end
                ST_LOW: begin
                    bitcnt_q <= bitcnt_q;
                end
                ST_HIGH: begin
                    if (go && tick) begin
                        shreg_q[bitcnt_q] <= sdata;
                        bitcnt_q          <= bitcnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign sclk       = sclk_q;
    assign shifting   = (state_q == ST_LOW) || (state_q == ST_HIGH);
    assign fsm_idle   = (state_q == ST_IDLE);
    assign word_valid = (state_q == ST_DONE);
    assign word       = shreg_q;

endmodule

// File: rtl/smr_regs.sv
module smr_regs
    import smr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             word_valid,
    input  logic [DW:0]      word,
    output logic [REG_W-1:0] ctrl,
    output logic [DIV_W-1:0] div,
    output logic             rx_done,
    output logic             rx_ovr,
    output logic             rx_ninth,
    output logic [DW-1:0]    rx_hold
);

    logic [REG_W-1:0] ctrl_q;
    logic [DIV_W-1:0] div_q;
    logic             done_q, ovr_q, ninth_q;
    logic [DW-1:0]    hold_q;
    logic             ctrl_wr, div_wr, data_rd, cont_fall;

    assign ctrl_wr   = wr_en && (addr == A_CTRL);
    assign div_wr    = wr_en && (addr == A_DIV);
    assign data_rd   = rd_en && (addr == A_DATA);
    assign cont_fall = ctrl_wr && ctrl_q[C_CONT] && !wr_data[C_CONT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q <= wr_data;
            end else if (word_valid) begin
                ctrl_q[C_SINGLE] <= 1'b0;
            end
            if (div_wr) div_q <= wr_data[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            ovr_q   <= 1'b0;
            ninth_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            if (cont_fall) ovr_q <= 1'b0;
            if (word_valid) begin
                if (done_q && !data_rd) begin
                    ovr_q <= 1'b1;
                end else begin
                    hold_q  <= word[DW-1:0];
                    ninth_q <= word[DW];
                    done_q  <= 1'b1;
                end
            end else if (data_rd) begin
                done_q <= 1'b0;
            end
        end
    end

    assign ctrl     = ctrl_q;
    assign div      = div_q;
    assign rx_done  = done_q;
    assign rx_ovr   = ovr_q;
    assign rx_ninth = ninth_q;
    assign rx_hold  = hold_q;

endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
    import smr_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             sclk_o,
    input  logic             sdata_i,
    output logic             irq_o
);

    logic [REG_W-1:0] ctrl;
    logic [DIV_W-1:0] div;
    logic             rx_done, rx_ovr, rx_ninth;
    logic [DW-1:0]    rx_hold;
    logic             tick, shifting, fsm_idle, word_valid, go;
    logic [DW:0]      word;

    assign go = ctrl[C_PORT] && (ctrl[C_SINGLE] || ctrl[C_CONT]);

    smr_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .word_valid (word_valid),
        .word       (word),
        .ctrl       (ctrl),
        .div        (div),
        .rx_done    (rx_done),
        .rx_ovr     (rx_ovr),
        .rx_ninth   (rx_ninth),
        .rx_hold    (rx_hold)
    );

    smr_baud #(.DIV_W(DIV_W)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (shifting),
        .div   (div),
        .tick  (tick)
    );

    smr_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .keep_on    (ctrl[C_CONT]),
        .nine       (ctrl[C_NINE]),
        .tick       (tick),
        .sdata      (sdata_i),
        .sclk       (sclk_o),
        .shifting   (shifting),
        .fsm_idle   (fsm_idle),
        .word_valid (word_valid),
        .word       (word)
    );

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CTRL: rd_data = ctrl;
            A_DIV:  rd_data = REG_W'(div);
            A_STAT: rd_data = REG_W'({!fsm_idle, rx_ninth, rx_ovr, rx_done});
            A_DATA: rd_data = REG_W'(rx_hold);
        endcase
    end

    assign irq_o = rx_done && ctrl[C_IRQEN];

endmodule

// File: rtl/smr_chk.sv
module smr_chk
    import smr_pkg::*;
#(
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [1:0]       addr,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] ctrl,
    input logic             sclk_o,
    input logic             fsm_idle,
    input logic             word_valid,
    input logic             rx_done,
    input logic             rx_ovr,
    input logic [DW-1:0]    rx_hold
);

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !sclk_o); // R3

    AST_SINGLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !(wr_en && addr == A_CTRL)) |=> !ctrl[C_SINGLE]); // R4

    AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> $past(word_valid)); // R8

    AST_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == A_DATA && !word_valid) |=> !rx_done); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && rx_done && !(rd_en && addr == A_DATA)) |=> rx_ovr); // R10

    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && rx_done && !(rd_en && addr == A_DATA)) |=> $stable(rx_hold)); // R10

    AST_OVR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && ctrl[C_CONT] && !wr_data[C_CONT]
         && !(word_valid && rx_done)) |=> !rx_ovr); // R11

endmodule

bind sync_master_rx smr_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .ctrl       (ctrl),
    .sclk_o     (sclk_o),
    .fsm_idle   (fsm_idle),
    .word_valid (word_valid),
    .rx_done    (rx_done),
    .rx_ovr     (rx_ovr),
    .rx_hold    (rx_hold)
);

// File: tb/tb_sync_master_rx.sv
`timescale 1ns/1ps
module tb_sync_master_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd2;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       sclk_o;
    logic       sdata_i = 1'b0;
    logic       irq_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [8:0] slv_word [4];
    int slv_bit = 0;
    int slv_idx = 0;
    int slv_n = 8;

    localparam int NV = 6;
    localparam int V_DIV  [NV] = '{0, 1, 3, 2, 0, 5};
    localparam int V_NINE [NV] = '{0, 0, 1, 1, 1, 0};
    localparam int V_DATA [NV] = '{'h0A5, 'h03C, 'h1F0, 'h0AA, 'h155, 'h081};

    sync_master_rx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .sclk_o(sclk_o),
        .sdata_i(sdata_i), .irq_o(irq_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // serial source: presents the next bit on each rising serial clock edge
    always @(posedge sclk_o) begin
        sdata_i = slv_word[slv_idx][slv_bit];
        slv_bit = slv_bit + 1;
        if (slv_bit >= slv_n) begin
            slv_bit = 0;
            if (slv_idx < 3) slv_idx = slv_idx + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slv_load(input int n, input int w0, input int w1, input int w2, input int w3);
        slv_n = n; slv_bit = 0; slv_idx = 0;
        slv_word[0] = 9'(w0); slv_word[1] = 9'(w1);
        slv_word[2] = 9'(w2); slv_word[3] = 9'(w3);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd2;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        addr = a;
        #1 v = rd_data;
        addr = 2'd2;
    endtask

    task automatic rd_data_reg(output logic [7:0] v);
        @(negedge clk);
        addr = 2'd3; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0; addr = 2'd2;
    endtask

    task automatic wait_stat(input int bitpos);
        logic [7:0] s;
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            peek(2'd2, s);
            if (s[bitpos]) return;
        end
    endtask

    initial begin
        wait (cyc == 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, d, kk, t0, t1, hi;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(2'd0, v); check("R1 ctrl", v, 0);
        peek(2'd1, v); check("R1 div", v, 0);
        peek(2'd2, v); check("R1 stat", v, 0);
        peek(2'd3, v); check("R1 data", v, 0);
        check("R1 sclk", sclk_o, 0);
        check("R1 irq", irq_o, 0);

        // vector table: one-shot words, exact flag timing
        for (int i = 0; i < NV; i++) begin
            d = V_DIV[i];
            n = V_NINE[i] ? 9 : 8;
            kk = 2 * n * (d + 1) + 2;
            slv_load(n, V_DATA[i], 0, 0, 0);
            wr(2'd1, 8'(d));
            wr(2'd0, 8'h03 | (V_NINE[i] ? 8'h08 : 8'h00));
            repeat (kk - 1) @(negedge clk);
            peek(2'd2, v); check("R12 flag early", v[0], 0);
            @(negedge clk);
            peek(2'd2, v); check("R12 R8 flag on time", v[0], 1);
            check("R7 ninth bit", v[2], (V_DATA[i] >> 8) & 1);
            peek(2'd0, v); check("R4 one-shot self-clear", v[1], 0);
            check("R4 sclk idle", sclk_o, 0);
            rd_data_reg(v); check("R3 R7 data LSB first", v, V_DATA[i] & 'hFF);
            peek(2'd2, v); check("R8 read clears flag", v[0], 0);
        end

        // R2 port disabled
        slv_load(8, 'hFF, 0, 0, 0);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h02);
        hi = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sclk_o) hi++;
        end
        check("R2 no clock when disabled", hi, 0);
        peek(2'd2, v); check("R2 no word when disabled", v[0], 0);
        wr(2'd0, 8'h00);

        // R3 serial clock rate, div=2
        slv_load(8, 'h5C, 0, 0, 0);
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h03);
        repeat (3) @(negedge clk); check("R3 first half low", sclk_o, 0);
        @(negedge clk); check("R3 rise", sclk_o, 1);
        repeat (2) @(negedge clk); check("R3 high width", sclk_o, 1);
        @(negedge clk); check("R3 fall", sclk_o, 0);
        wait_stat(0);
        rd_data_reg(v); check("R3 word at div 2", v, 'h5C);

        // R9 interrupt gating
        slv_load(8, 'h77, 0, 0, 0);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'h03);
        wait_stat(0);
        check("R9 irq masked", irq_o, 0);
        wr(2'd0, 8'h11);
        #1 check("R9 irq enabled", irq_o, 1);
        rd_data_reg(v); check("R9 data", v, 'h77);
        #1 check("R9 irq after read", irq_o, 0);
        wr(2'd0, 8'h00);

        // R5 continuous mode, R10 overrun, R11 clear
        slv_load(8, 'h11, 'h22, 'h33, 'h44);
        wr(2'd1, 8'd1);
        wr(2'd0, 8'h05);
        wait_stat(0); t0 = cyc;
        rd_data_reg(v); check("R5 word 1", v, 'h11);
        wait_stat(0); t1 = cyc;
        check("R5 back-to-back spacing", t1 - t0, 33);
        rd_data_reg(v); check("R5 word 2", v, 'h22);
        peek(2'd0, v); check("R5 continuous enable kept", v[2], 1);
        wait_stat(0);
        wait_stat(1);
        peek(2'd2, v); check("R10 overrun set", v[1], 1);
        rd_data_reg(v); check("R10 new word discarded", v, 'h33);
        wr(2'd0, 8'h01);
        peek(2'd2, v); check("R11 overrun cleared", v[1], 0);
        repeat (2) @(negedge clk);
        peek(2'd2, v); check("R5 stops when cleared", v[3], 0);
        check("R5 sclk low after stop", sclk_o, 0);
        @(negedge clk);
        peek(2'd2, v);
        if (v[0]) rd_data_reg(v);

        // R6 both enables set
        slv_load(8, 'h5A, 'h6B, 0, 0);
        wr(2'd0, 8'h07);
        wait_stat(0);
        peek(2'd0, v); check("R6 one-shot bit cleared", v[1], 0);
        check("R6 continuous bit kept", v[2], 1);
        rd_data_reg(v); check("R6 word 1", v, 'h5A);
        wait_stat(0);
        rd_data_reg(v); check("R6 reception continued", v, 'h6B);
        wr(2'd0, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule